// File: doc/BRIEF.md
# Block Address Translation Matcher

This block holds two small banks of block-translation entries, one searched by instruction fetches and one by loads and stores. Each entry is a pair of 32-bit words. The upper word names an aligned region of effective address space, gives its size, and says which privilege levels may use it. The lower word gives the physical base of the region and a two-bit protection code. A lookup presents a 32-bit effective address, a fetch/data select and the privilege state. One cycle later the block reports whether an entry covered the address, the translated address aligned to a 4 KiB page, and a read/write/execute permission vector.

Entries are written one word at a time through a simple write port. When several entries cover the same address, the entry with the lowest index is used. On a miss the outputs carry zeros, and the next translation stage handles the address. The number of entries in each bank is a parameter. With zero entries the block never reports a hit.

Top module: `blk_xlate_match`

## Requirements
- R1: After reset no lookup response is pending and every entry is invalid, so a lookup made before any write misses.
- R2: A lookup with `req_ifetch`=1 searches only the instruction bank (`wr_ibank`=1 at write time). A lookup with `req_ifetch`=0 searches only the data bank.
- R3: An entry can hit only when the upper-word valid bit for the current privilege is set. Bit 0 enables user lookups (`req_user`=1) and bit 1 enables supervisor lookups.
- R4: Upper-word bits 31:17 hold the region tag and bits 12:2 hold a size field. The compare mask is 0xFFFE0000 with (size field << 15) cleared, so each set size bit stops one address bit, from bit 17 upward, from being compared.
- R5: A hit requires the effective address ANDed with the mask to equal the upper word's tag bits. On a miss `rsp_hit`, `rsp_pa` and `rsp_prot` are all zero.
- R6: On a hit `rsp_pa` = ((lower & mask) | (ea & ~mask)) with bits 11:0 forced to zero.
- R7: Lower-word bits 1:0 select protection, given on `rsp_prot` as {exec, write, read}. Code 0 gives 000, code 2 gives 111, and codes 1 and 3 give 101.
- R8: When several valid entries match, the result comes from the lowest-index one.
- R9: `rsp_valid` is high exactly one cycle after a cycle with `req_valid` high. The lookup uses the entries as they stood before that edge.
- R10: With `NUM_ENTRIES`=0 every lookup misses, whatever has been written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write one entry word |
| wr_ibank | input | 1 | 1 selects the instruction bank, 0 the data bank |
| wr_idx | input | IDX_W (2) | Entry index to write |
| wr_lower | input | 1 | 1 writes the lower word, 0 the upper word |
| wr_data | input | 32 | Word value to write |
| req_valid | input | 1 | Lookup request |
| req_ea | input | 32 | Effective address |
| req_ifetch | input | 1 | 1 for instruction fetch, 0 for load/store |
| req_user | input | 1 | 1 for user privilege, 0 for supervisor |
| rsp_valid | output | 1 | Response for the request of the previous cycle |
| rsp_hit | output | 1 | An entry covered the address |
| rsp_pa | output | 32 | Page-aligned physical address |
| rsp_prot | output | 3 | {exec, write, read} permissions |

## Verification
The assertions take for granted that the address and select inputs are stable and known in every cycle where `req_valid` is high. They also assume that writes to the entries are not mixed into assertion-relevant timing beyond the documented old-contents rule. The property that bits 16:12 of the result follow the request relies on the mask never covering address bits below 17, which holds for every size-field value. The stimulus drives all inputs on the falling edge, keeps writes and lookups in separate cycles, and uses only the defined size, valid and protection encodings, so every response can be predicted from the entries the bench has written.

// File: rtl/bat_pkg.sv
package bat_pkg;

    localparam int ADDR_W     = 32;
    localparam int PAGE_BITS  = 12;
    localparam int BLEN_SHIFT = 15;
    localparam int UVALID_BIT = 0;
    localparam int SVALID_BIT = 1;

    localparam logic [ADDR_W-1:0] TAG_MASK  = 32'hFFFE_0000;
    localparam logic [ADDR_W-1:0] BLEN_MASK = 32'h0000_1FFC;
    localparam logic [ADDR_W-1:0] PAGE_MASK = ~((32'd1 << PAGE_BITS) - 32'd1);

    typedef enum logic [1:0] {
        PP_DENY  = 2'd0,
        PP_RX_LO = 2'd1,
        PP_FULL  = 2'd2,
        PP_RX_HI = 2'd3
    } blk_pp_e;

    typedef struct packed {
        logic x;
        logic w;
        logic r;
    } prot_t;

    typedef struct packed {
        logic [ADDR_W-1:0] upper;
        logic [ADDR_W-1:0] lower;
    } blk_pair_t;

    typedef struct packed {
        logic              hit;
        logic [ADDR_W-1:0] pa;
        prot_t             prot;
    } blk_res_t;

    function automatic logic [ADDR_W-1:0] blk_mask(input logic [ADDR_W-1:0] upper,
                                                    input logic user);
        logic en;
        en = user ? upper[UVALID_BIT] : upper[SVALID_BIT];
        return en ? (TAG_MASK & ~((upper & BLEN_MASK) << BLEN_SHIFT)) : '0;
    endfunction

    function automatic prot_t blk_prot(input logic [1:0] code);
        prot_t p;
        case (blk_pp_e'(code))
            PP_DENY: p = '{x: 1'b0, w: 1'b0, r: 1'b0};
            PP_FULL: p = '{x: 1'b1, w: 1'b1, r: 1'b1};
            default: p = '{x: 1'b1, w: 1'b0, r: 1'b1};
        endcase
        return p;
    endfunction

endpackage

// File: rtl/bat_bank.sv
module bat_bank
    import bat_pkg::*;
#(
    parameter int NUM_ENTRIES = 4,
    parameter int SLOTS       = 4,
    parameter int IDX_W       = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [IDX_W-1:0]         wr_idx,
    input  logic                     wr_lower,
    input  logic [ADDR_W-1:0]        wr_data,
    output blk_pair_t [SLOTS-1:0]    pairs
);

    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        if (i < NUM_ENTRIES) begin : g_live
            logic sel;
            assign sel = wr_en && (wr_idx == IDX_W'(i));

            always_ff @(posedge clk) begin
                if (rst) begin
                    pairs[i] <= '0;
                end else if (sel) begin
                    if (wr_lower) pairs[i].lower <= wr_data;
                    else          pairs[i].upper <= wr_data;
                end
            end
        end else begin : g_dead
            assign pairs[i] = '0;
        end
    end

endmodule

// File: rtl/bat_entry_eval.sv
module bat_entry_eval
    import bat_pkg::*;
(
    input  blk_pair_t          pair,
    input  logic [ADDR_W-1:0]  ea,
    input  logic               user,
    output blk_res_t           res
);

    logic [ADDR_W-1:0] mask;
    logic [ADDR_W-1:0] joined;

    always_comb begin
        mask     = blk_mask(pair.upper, user);
        joined   = (pair.lower & mask) | (ea & ~mask);
        res.hit  = (mask != '0) && ((ea & mask) == (pair.upper & TAG_MASK));
        res.pa   = joined & PAGE_MASK;
        res.prot = blk_prot(pair.lower[1:0]);
    end

endmodule

// File: rtl/bat_prio_sel.sv
module bat_prio_sel
    import bat_pkg::*;
#(
    parameter int SLOTS = 4
) (
    input  blk_res_t [SLOTS-1:0] cand,
    output blk_res_t             pick
);

    always_comb begin
        pick = '0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (cand[i].hit) pick = cand[i];
        end
    end

endmodule

// File: rtl/blk_xlate_match.sv
module blk_xlate_match
    import bat_pkg::*;
#(
    parameter int NUM_ENTRIES = 4,
    localparam int SLOTS      = (NUM_ENTRIES > 0) ? NUM_ENTRIES : 1,
    localparam int IDX_W      = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_ibank,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_lower,
    input  logic [31:0]       wr_data,
    input  logic              req_valid,
    input  logic [31:0]       req_ea,
    input  logic              req_ifetch,
    input  logic              req_user,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [31:0]       rsp_pa,
    output logic [2:0]        rsp_prot
);

    localparam int NBANKS = 2; // index 0: data, index 1: instruction

    blk_pair_t [SLOTS-1:0] bank_pairs [NBANKS];
    blk_pair_t [SLOTS-1:0] search_set;
    blk_res_t  [SLOTS-1:0] cand;
    blk_res_t              winner;
    blk_res_t              found;
    blk_res_t              res_q;
    logic                  valid_q;

    for (genvar b = 0; b < NBANKS; b++) begin : g_bank
        logic bank_we;
        assign bank_we = wr_en && (wr_ibank == (b == 1));

        bat_bank #(
            .NUM_ENTRIES (NUM_ENTRIES),
            .SLOTS       (SLOTS),
            .IDX_W       (IDX_W)
        ) u_bank (
            .clk      (clk),
            .rst      (rst),
            .wr_en    (bank_we),
            .wr_idx   (wr_idx),
            .wr_lower (wr_lower),
            .wr_data  (wr_data),
            .pairs    (bank_pairs[b])
        );
    end

    assign search_set = req_ifetch ? bank_pairs[1] : bank_pairs[0];

    for (genvar i = 0; i < SLOTS; i++) begin : g_eval
        bat_entry_eval u_eval (
            .pair (search_set[i]),
            .ea   (req_ea),
            .user (req_user),
            .res  (cand[i])
        );
    end

    bat_prio_sel #(.SLOTS(SLOTS)) u_sel (
        .cand (cand),
        .pick (winner)
    );

    if (NUM_ENTRIES == 0) begin : g_empty
        assign found = '0;
    end else begin : g_search
        assign found = winner;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            res_q   <= '0;
        end else begin
            valid_q <= req_valid;
            res_q   <= req_valid ? found : '0;
        end
    end

    assign rsp_valid = valid_q;
    assign rsp_hit   = res_q.hit;
    assign rsp_pa    = res_q.pa;
    assign rsp_prot  = res_q.prot;

endmodule

// File: rtl/bat_match_chk.sv
module bat_match_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic [31:0] req_ea,
    input logic        rsp_valid,
    input logic        rsp_hit,
    input logic [31:0] rsp_pa,
    input logic [2:0]  rsp_prot
);

    // R9
    a_r9_resp_follows: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);
    // R9
    a_r9_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);
    // R5
    a_r5_miss_quiet: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_hit) |-> (rsp_pa == 32'd0 && rsp_prot == 3'd0));
    // R6
    a_r6_page_aligned: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_pa[11:0] == 12'd0));
    // R6
    a_r6_offset_kept: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_hit) |-> (rsp_pa[16:12] == $past(req_ea[16:12])));
    // R7
    a_r7_prot_legal: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_hit) |->
            (rsp_prot == 3'b000 || rsp_prot == 3'b101 || rsp_prot == 3'b111));
    // R1
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> !rsp_hit);

endmodule

bind blk_xlate_match bat_match_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ea    (req_ea),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .rsp_pa    (rsp_pa),
    .rsp_prot  (rsp_prot)
);

// File: tb/tb_blk_xlate_match.sv
module tb_blk_xlate_match;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        wr_ibank = 1'b0;
    logic [1:0]  wr_idx = 2'd0;
    logic        wr_lower = 1'b0;
    logic [31:0] wr_data = 32'd0;
    logic        req_valid = 1'b0;
    logic [31:0] req_ea = 32'd0;
    logic        req_ifetch = 1'b0;
    logic        req_user = 1'b0;
    logic        rsp_valid, rsp_hit;
    logic [31:0] rsp_pa;
    logic [2:0]  rsp_prot;
    logic        e_valid, e_hit;
    logic [31:0] e_pa;
    logic [2:0]  e_prot;

    always #4 clk = ~clk;

    blk_xlate_match #(.NUM_ENTRIES(4)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_ibank(wr_ibank),
        .wr_idx(wr_idx), .wr_lower(wr_lower), .wr_data(wr_data),
        .req_valid(req_valid), .req_ea(req_ea), .req_ifetch(req_ifetch),
        .req_user(req_user), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_pa(rsp_pa), .rsp_prot(rsp_prot)
    );

    blk_xlate_match #(.NUM_ENTRIES(0)) dut_empty (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_ibank(wr_ibank),
        .wr_idx(wr_idx[0]), .wr_lower(wr_lower), .wr_data(wr_data),
        .req_valid(req_valid), .req_ea(req_ea), .req_ifetch(req_ifetch),
        .req_user(req_user), .rsp_valid(e_valid), .rsp_hit(e_hit),
        .rsp_pa(e_pa), .rsp_prot(e_prot)
    );

    int total = 0;
    int bad   = 0;
    bit armed = 1'b0;

    logic [31:0] sh_up [2][4];
    logic [31:0] sh_lo [2][4];

    logic        q_hit  [$];
    logic [31:0] q_pa   [$];
    logic [2:0]  q_prot [$];
    string       q_tag  [$];

    task automatic check(input logic [63:0] act, input logic [63:0] exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Reference from the requirement text.
    task automatic model(input logic [31:0] ea, input logic ifetch, input logic user,
                         output logic hit, output logic [31:0] pa, output logic [2:0] prot);
        int b;
        b = ifetch ? 1 : 0;
        hit = 1'b0; pa = 32'd0; prot = 3'd0;
        for (int i = 3; i >= 0; i--) begin
            logic [31:0] up, lo, m;
            logic en;
            up = sh_up[b][i];
            lo = sh_lo[b][i];
            en = user ? up[0] : up[1];
            m  = 32'hFFFE_0000 & ~({19'd0, up[12:2], 2'd0} << 15);
            if (en && ((ea & m) == (up & 32'hFFFE_0000))) begin
                hit = 1'b1;
                pa  = ((lo & m) | (ea & ~m)) & 32'hFFFF_F000;
                case (lo[1:0])
                    2'd0: prot = 3'b000;
                    2'd2: prot = 3'b111;
                    default: prot = 3'b101;
                endcase
            end
        end
    endtask

    task automatic put(input logic ibank, input int idx, input logic lower, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b0;
        wr_en = 1'b1; wr_ibank = ibank; wr_idx = 2'(idx); wr_lower = lower; wr_data = d;
        if (lower) sh_lo[ibank ? 1 : 0][idx] = d;
        else       sh_up[ibank ? 1 : 0][idx] = d;
    endtask

    task automatic look(input logic [31:0] ea, input logic ifetch, input logic user, input string tag);
        logic h; logic [31:0] p; logic [2:0] pr;
        @(negedge clk);
        wr_en = 1'b0;
        req_valid = 1'b1; req_ea = ea; req_ifetch = ifetch; req_user = user;
        model(ea, ifetch, user, h, p, pr);
        q_hit.push_back(h); q_pa.push_back(p); q_prot.push_back(pr); q_tag.push_back(tag);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            wr_en = 1'b0; req_valid = 1'b0;
        end
    endtask

    // Monitor: pops one expected item per response.
    always @(posedge clk) begin
        #2;
        if (armed) begin
            check({63'd0, rsp_valid}, {63'd0, q_hit.size() != 0}, "R9 response timing");
            if (rsp_valid && q_hit.size() != 0) begin
                logic h; logic [31:0] p; logic [2:0] pr; string t;
                h = q_hit.pop_front(); p = q_pa.pop_front();
                pr = q_prot.pop_front(); t = q_tag.pop_front();
                check({63'd0, rsp_hit}, {63'd0, h}, {t, " hit"});
                check({32'd0, rsp_pa}, {32'd0, p}, {t, " pa"});
                check({61'd0, rsp_prot}, {61'd0, pr}, {t, " prot"});
            end
            if (e_valid) check({63'd0, e_hit}, 64'd0, "R10 empty bank never hits");
        end
    end

    initial begin
        #(8 * 20000);
        bad++; total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int b = 0; b < 2; b++)
            for (int i = 0; i < 4; i++) begin sh_up[b][i] = 0; sh_lo[b][i] = 0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check({63'd0, rsp_valid}, 64'd0, "R1 reset state");
        armed = 1'b1;

        // R1: nothing valid yet
        look(32'h1001_2345, 1'b0, 1'b0, "R1 unwritten miss");
        look(32'h0000_0000, 1'b1, 1'b1, "R1 unwritten miss fetch");

        // Data entry 0: 128 KiB supervisor-only, full access
        put(1'b0, 0, 1'b0, 32'h1000_0002);
        put(1'b0, 0, 1'b1, 32'h8000_0002);
        look(32'h1001_2345, 1'b0, 1'b0, "R5 R6 R7 data hit");
        look(32'h1001_2345, 1'b0, 1'b1, "R3 user blocked");
        look(32'h1001_2345, 1'b1, 1'b0, "R2 fetch misses data bank");
        look(32'h1002_0000, 1'b0, 1'b0, "R4 just outside block");

        // Instruction entry 0: 256 MiB user-only, code 1
        put(1'b1, 0, 1'b0, 32'h2000_1FFD);
        put(1'b1, 0, 1'b1, 32'h4000_0001);
        look(32'h2ABC_D123, 1'b1, 1'b1, "R4 R6 R7 max size fetch");
        look(32'h2ABC_D123, 1'b1, 1'b0, "R3 supervisor blocked");
        look(32'h2ABC_D123, 1'b0, 1'b1, "R2 data misses fetch bank");

        // Priority: data 1 and 2 both cover 0x3000_0000
        put(1'b0, 1, 1'b0, 32'h3000_0003);
        put(1'b0, 1, 1'b1, 32'h5000_0003);
        put(1'b0, 2, 1'b0, 32'h3000_0003);
        put(1'b0, 2, 1'b1, 32'h6000_0002);
        look(32'h3001_F0FF, 1'b0, 1'b1, "R8 lowest index wins");
        put(1'b0, 1, 1'b0, 32'h3000_0000);
        look(32'h3001_F0FF, 1'b0, 1'b0, "R8 next entry after disable");

        // Deny code with a hit; mid-size block
        put(1'b0, 3, 1'b0, 32'h7000_0003);
        put(1'b0, 3, 1'b1, 32'h9000_0000);
        look(32'h7000_1ABC, 1'b0, 1'b0, "R7 deny code");
        put(1'b0, 0, 1'b0, 32'h1000_003E);
        put(1'b0, 0, 1'b1, 32'h81E0_0002);
        look(32'h101F_F456, 1'b0, 1'b0, "R4 R6 2 MiB block");
        look(32'h1020_0000, 1'b0, 1'b0, "R4 2 MiB boundary miss");

        // Back-to-back lookups, then idle
        look(32'h7000_0000, 1'b0, 1'b1, "R9 back to back a");
        look(32'h2000_0000, 1'b1, 1'b1, "R9 back to back b");
        idle(3);
        check({63'd0, rsp_valid}, 64'd0, "R9 idle no response");
        check({63'd0, e_valid}, 64'd0, "R10 empty idle");
        idle(2);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule